// File: doc/BRIEF.md
# Floating-Point Status Exception and Trap Unit

This block holds the 32-bit floating-point status word and handles everything on its exception side. When the arithmetic datapath completes an operation, it presents the five IEEE flags it raised together with a completion strobe. The flags are sampled once, on that strobe. The datapath clears its own flag collector before each operation, so every strobe carries only the flags of that one operation.

The sampled flags are ORed into the current-exception field. The unit then compares that field with the trap-enable field. If any enabled exception is present, it records the IEEE-exception trap type and pulses a trap request to the CPU. Otherwise the current bits are folded into the accrued field.

The unit also decodes the rounding-direction field into a one-hot select for the datapath. It accepts a software load that replaces only the writable bits of the word.

Top module: `fp_status_unit`

## Requirements
- R1: After reset the status word `fsr_q` is all zeros, `fp_trap` is low and `rnd_sel` selects round-to-nearest-even (4'b0001).
- R2: On `op_done` with a nonzero `op_flags` vector (bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact), each raised flag is ORed into the current-exception field `fsr_q[4:0]`, using the same bit position.
- R3: If the updated current-exception field ANDed with the trap-enable field `fsr_q[27:23]` is nonzero, the trap-type field `fsr_q[16:14]` becomes 3'b001 and the accrued field is left unchanged.
- R4: If no enabled exception is present after a flagged operation, the updated current-exception bits are ORed into the accrued field `fsr_q[9:5]`.
- R5: With `op_done` low, or with `op_done` high and `op_flags` all zero, and no load, the status word keeps its value.
- R6: `rnd_sel` decodes `fsr_q[31:30]`: 00 gives 4'b0001 (nearest-even), 01 gives 4'b0010 (toward zero), 10 gives 4'b0100 (toward +inf) and 11 gives 4'b1000 (toward -inf). Any value the decoder does not recognise selects toward zero.
- R7: On `ld_en`, the bits set in the writable mask 32'hCF80_03FF take their values from `ld_data` and every other bit keeps its old value. `rnd_sel` reflects the loaded rounding field in the cycle after the load.
- R8: When `ld_en` and a flagged `op_done` occur in the same cycle, the load is merged first. The flags are then applied to the loaded word, and the trap decision uses the newly loaded enables.
- R9: `fp_trap` is high for exactly the one cycle that follows the clock edge that samples a trapping operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_done | input | 1 | Strobe: an FP operation completed and its flags are valid |
| op_flags | input | 5 | IEEE flags of that operation {nv, of, uf, dz, nx} |
| ld_en | input | 1 | Software load of the status word |
| ld_data | input | 32 | Value to load, merged under the writable mask |
| fsr_q | output | 32 | Current status word |
| rnd_sel | output | 4 | One-hot rounding direction for the datapath |
| fp_trap | output | 1 | One-cycle FP exception trap request |

## Verification
A software load and a completing flagged operation can arrive in the same clock cycle. This collision is hard to get right because the trap decision must see the enables that are being written in that same cycle. The bench provokes it in two ways. Directed cases load a word that turns an enable on or off together with an operation that raises the matching flag. The random stream also asserts `ld_en` and `op_done` together on a good share of its cycles. Each result is judged against a bench model that applies the load merge first and the flag update second, comparing the status word, the trap pulse and the rounding select one cycle after the edge.

// File: rtl/fp_status_unit.sv
module fp_status_unit #(
  parameter int          W        = 32,
  parameter int          NFLAG    = 5,
  parameter int          AEXC_LSB = 5,
  parameter int          TEM_LSB  = 23,
  parameter int          FTT_LSB  = 14,
  parameter int          RD_LSB   = 30,
  parameter logic [2:0]  FTT_IEEE = 3'd1,
  parameter logic [31:0] LD_MASK  = 32'hCF80_03FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_done,
  input  logic [NFLAG-1:0] op_flags,
  input  logic             ld_en,
  input  logic [W-1:0]     ld_data,
  output logic [W-1:0]     fsr_q,
  output logic [3:0]       rnd_sel,
  output logic             fp_trap
);

  localparam int AEXC_MSB = AEXC_LSB + NFLAG - 1;
  localparam int TEM_MSB  = TEM_LSB + NFLAG - 1;
  localparam int FTT_MSB  = FTT_LSB + 2;
  localparam int RD_MSB   = RD_LSB + 1;

  logic [W-1:0]     fsr_r, base, nxt;
  logic [NFLAG-1:0] cexc_n;
  logic             hit, trap_n, trap_r;

  assign base   = ld_en ? ((ld_data & LD_MASK) | (fsr_r & ~LD_MASK)) : fsr_r;
  assign hit    = op_done && (op_flags != '0);
  assign cexc_n = base[NFLAG-1:0] | op_flags;
  assign trap_n = hit && ((cexc_n & base[TEM_MSB:TEM_LSB]) != '0);

  always_comb begin
    nxt = base;
    if (hit) begin
      nxt[NFLAG-1:0] = cexc_n;
      if (trap_n) nxt[FTT_MSB:FTT_LSB] = FTT_IEEE;
      else        nxt[AEXC_MSB:AEXC_LSB] = base[AEXC_MSB:AEXC_LSB] | cexc_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_r  <= '0;
      trap_r <= 1'b0;
    end else begin
      fsr_r  <= nxt;
      trap_r <= trap_n;
    end
  end

  always_comb begin
    case (fsr_r[RD_MSB:RD_LSB])
      2'b00:   rnd_sel = 4'b0001;
      2'b10:   rnd_sel = 4'b0100;
      2'b11:   rnd_sel = 4'b1000;
      default: rnd_sel = 4'b0010;
    endcase
  end

  assign fsr_q   = fsr_r;
  assign fp_trap = trap_r;

  AST_RND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rnd_sel) == 1); // R6

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && (!op_done || op_flags == '0)) |=> $stable(fsr_q)); // R5

  AST_LOAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !op_done) |=> ((fsr_q & ~LD_MASK) == ($past(fsr_q) & ~LD_MASK))); // R7

  AST_TRAP_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    fp_trap |-> (fsr_q[FTT_MSB:FTT_LSB] == FTT_IEEE
                 && (fsr_q[NFLAG-1:0] & fsr_q[TEM_MSB:TEM_LSB]) != '0)); // R3

  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_done || op_flags == '0) |=> !fp_trap); // R9

  AST_ACCRUE_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ld_en) |=> ((fsr_q[AEXC_MSB:AEXC_LSB] & $past(fsr_q[AEXC_MSB:AEXC_LSB]))
                          == $past(fsr_q[AEXC_MSB:AEXC_LSB]))); // R4

endmodule

// File: tb/fp_status_unit_tb.sv
`timescale 1ns/1ps
module fp_status_unit_tb_top;
  localparam logic [31:0] MASK = 32'hCF80_03FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_done = 1'b0;
  logic [4:0]  op_flags = '0;
  logic        ld_en = 1'b0;
  logic [31:0] ld_data = '0;
  logic [31:0] fsr_q;
  logic [3:0]  rnd_sel;
  logic        fp_trap;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_fsr = '0;
  logic        m_trap = 1'b0;

  always #10 clk = ~clk;

  fp_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_flags(op_flags),
    .ld_en(ld_en), .ld_data(ld_data), .fsr_q(fsr_q), .rnd_sel(rnd_sel),
    .fp_trap(fp_trap)
  );

  function automatic logic [3:0] exp_rnd(input logic [31:0] f);
    case (f[31:30])
      2'b00: return 4'b0001;
      2'b01: return 4'b0010;
      2'b10: return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  function automatic logic [32:0] model(input logic [31:0] f, input logic od,
      input logic [4:0] fl, input logic ld, input logic [31:0] d);
    logic [31:0] w;
    logic [4:0]  c;
    logic        t;
    w = ld ? ((d & MASK) | (f & ~MASK)) : f;
    t = 1'b0;
    if (od && fl != 0) begin
      c = w[4:0] | fl;
      w[4:0] = c;
      if ((c & w[27:23]) != 0) begin
        t = 1'b1;
        w[16:14] = 3'b001;
      end else w[9:5] = w[9:5] | c;
    end
    return {t, w};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic od, input logic [4:0] fl,
                      input logic ld, input logic [31:0] d);
    logic [32:0] r;
    op_done = od; op_flags = fl; ld_en = ld; ld_data = d;
    r = model(m_fsr, od, fl, ld, d);
    @(posedge clk);
    #5;
    m_fsr = r[31:0]; m_trap = r[32];
    op_done = 1'b0; op_flags = '0; ld_en = 1'b0;
    chk({req, " fsr"}, fsr_q, m_fsr);
    chk({req, " trap"}, {31'd0, fp_trap}, {31'd0, m_trap});
    chk({req, " rnd"}, {28'd0, rnd_sel}, {28'd0, exp_rnd(m_fsr)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #5;
    rst_n = 1'b1;
    chk("R1 reset fsr", fsr_q, 32'h0);
    chk("R1 reset trap", {31'd0, fp_trap}, 32'h0);
    chk("R1 reset rnd", {28'd0, rnd_sel}, 32'h1);

    // R5: no op, and op with zero flags
    step("R5 idle", 1'b0, 5'h1F, 1'b0, 32'h0);
    step("R5 zero flags", 1'b1, 5'h00, 1'b0, 32'h0);

    // R2 / R4: inexact only, no enables -> accrue
    step("R2 R4 nx", 1'b1, 5'h01, 1'b0, 32'h0);
    step("R2 R4 of", 1'b1, 5'h08, 1'b0, 32'h0);

    // R7: load all ones: only masked bits change, ftt kept
    step("R7 load", 1'b0, 5'h0, 1'b1, 32'hFFFF_FFFF);
    step("R7 load clear", 1'b0, 5'h0, 1'b1, 32'h0000_0000);

    // R6: every rounding code
    for (int i = 0; i < 4; i++)
      step("R6 rnd", 1'b0, 5'h0, 1'b1, {i[1:0], 30'h0});

    // R3 / R9: enable dz, raise dz -> trap, then pulse drops
    step("R7 load enables", 1'b0, 5'h0, 1'b1, 32'h0100_0000);
    step("R3 trap dz", 1'b1, 5'h02, 1'b0, 32'h0);
    step("R9 pulse ends", 1'b0, 5'h0, 1'b0, 32'h0);

    // R8: same-cycle load turns enable for nv on, op raises nv
    step("R8 clear", 1'b0, 5'h0, 1'b1, 32'h0);
    step("R8 load+op trap", 1'b1, 5'h10, 1'b1, 32'h0800_0000);
    // R8: same-cycle load turns enables off, op raises flag -> accrue
    step("R8 load+op accrue", 1'b1, 5'h04, 1'b1, 32'h4000_0000);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic od, ld;
      logic [4:0] fl;
      logic [31:0] d;
      od = ($urandom % 3) != 0;
      ld = ($urandom % 4) == 0;
      fl = (($urandom % 3) == 0) ? 5'h0 : 5'($urandom);
      d  = $urandom;
      if (($urandom % 2) == 0) d[27:23] = 5'h0;
      if (($urandom % 3) == 0) d[4:0] = 5'h0;
      step(ld && od ? "R8 rand" : (od ? "R2 R3 R4 rand" : (ld ? "R7 rand" : "R5 rand")),
           od, fl, ld, d);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule